// File: doc/BRIEF.md
# Configurable UART Framing Core

This block is the bit-level engine of an asynchronous serial port. It owns one transmit line and one receive line and turns bytes into framed characters and back again. A 16-bit divisor, loaded one byte at a time, sets the length of a bit to sixteen times the divisor in clock cycles. The character length (5 to 8 data bits), the stop length, the parity mode and the break request are all inputs that can change at run time. Register decoding, FIFOs and interrupt logic sit outside. They reach the core through a valid/ready byte port on each side and a status-clear strobe.

The transmitter holds one byte in a holding register while the previous character is still being shifted out. Its state machine has the states TX_IDLE, TX_START, TX_DATA, TX_PARITY and TX_STOP. It moves from TX_IDLE to TX_START when the holding register is full (launch). It moves from TX_START to TX_DATA at the end of the start bit, and from TX_DATA to TX_PARITY or TX_STOP after the last data bit. It moves from TX_PARITY to TX_STOP after the parity bit, and from TX_STOP back to TX_IDLE when the stop time has run out.

The receiver first passes the line through a two-stage synchronizer and then samples it at sixteen times the bit rate. Its states are RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP and RX_WAIT_HIGH. On a tick that sees the line low, it goes from RX_IDLE to RX_START. At the middle of the start bit it goes on to RX_DATA, or back to RX_IDLE if the line is high again. From RX_DATA it goes to RX_PARITY or RX_STOP after the last data bit, and from RX_PARITY to RX_STOP. At the middle of the stop bit it goes to RX_IDLE if the line is high, or to RX_WAIT_HIGH if it is low. RX_WAIT_HIGH goes back to RX_IDLE once the line is high again.

Top module: `uart_frame_core`

## Requirements
- R1: After reset, txd is 1, tx_ready is 1, tx_empty is 1, rx_valid is 0 and all four status flags are 0.
- R2: A bit lasts 16 × D clock cycles. D is {high byte, low byte}: div_lo_wr loads div_byte into bits 7:0 and div_hi_wr loads it into bits 15:8. D resets to DIV_INIT, and a value of 0 acts as 1.
- R3: A transmitted frame is one low start bit, then N = 5 + wlen_sel data bits sent least significant bit first, then the optional parity bit, then the stop time at 1. Data bits above N are not sent.
- R4: When par_en is 1, a parity bit follows the data. par_mode 0 makes the count of ones in the data plus parity odd, 1 makes it even, 2 forces the bit to 1 and 3 forces it to 0. When par_en is 0, no parity bit is sent and none is checked.
- R5: With stop_sel 0 the stop time is one bit. With stop_sel 1 it is two bits, or 1.5 bits when wlen_sel is 0.
- R6: While brk_ctl is 1, txd is 0 within two cycles. After brk_ctl returns to 0 with the transmitter idle, txd returns to 1.
- R7: tx_ready is 1 exactly when the holding register is empty, and a byte is taken when tx_valid and tx_ready are both 1. tx_empty is 1 only when the holding register is empty and no frame is being sent, so a second byte can be accepted while the first is on the line.
- R8: The receiver samples each bit at the middle of its 16 ticks. It raises rx_valid with the character after the middle of the first stop bit. Bits of rx_data at N and above are 0. rx_valid falls when rx_ready is 1.
- R9: When par_en is 1 and the received parity bit differs from the one R4 gives, st_parity is set. The character is still delivered.
- R10: A low first stop bit sets st_framing.
- R11: When data, parity and first stop bit all sample low, st_break and st_framing are set and a zero character is delivered. The receiver then waits for the line to go high before it looks for a new start bit.
- R12: If a character completes while rx_valid is 1 and rx_ready is 0, st_overrun is set and the older character stays in rx_data.
- R13: The four status flags stay set until a stat_clr pulse, which clears all of them. An event in the same cycle as the clear wins.
- R14: A low pulse on rxd shorter than half a bit starts no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_byte | input | 8 | Byte written into the divisor |
| div_lo_wr | input | 1 | Load div_byte into the divisor low byte |
| div_hi_wr | input | 1 | Load div_byte into the divisor high byte |
| wlen_sel | input | 2 | Data bits minus 5 |
| stop_sel | input | 1 | 0: one stop bit, 1: two (1.5 for 5-bit words) |
| par_en | input | 1 | Enable parity generation and checking |
| par_mode | input | 2 | 0 odd, 1 even, 2 forced 1, 3 forced 0 |
| brk_ctl | input | 1 | Drive a break on txd |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Holding register empty, byte can be taken |
| tx_empty | output | 1 | No character anywhere in the transmitter |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | Received character ready |
| rx_data | output | 8 | Received character, zero-extended |
| rx_ready | input | 1 | Consumer takes the received character |
| stat_clr | input | 1 | Clear the sticky status flags |
| st_overrun | output | 1 | Sticky overrun flag |
| st_parity | output | 1 | Sticky parity error flag |
| st_framing | output | 1 | Sticky framing error flag |
| st_break | output | 1 | Sticky break flag |

## Verification
The bench builds the core with OSR 16, DIV_W 16 and DIV_INIT 1. It first measures frame lengths at the reset divisor of one, then loads a divisor of 2 so that each bit takes 32 cycles. At these sizes a frame of every word length, parity mode and stop length fits in a few hundred cycles, which makes room to sweep the whole configuration space in loopback. It also leaves time to drive hand-made bad frames, break frames and start-bit glitches into the receiver. Frame-to-frame spacing shows the 1.5-stop case and the back-to-back holding-register path directly.

// File: rtl/uart_frame_pkg.sv
package uart_frame_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_MARK  = 2'd2,
        PAR_SPACE = 2'd3
    } par_mode_e;

    // Index of the last data bit for a word-length select (5..8 bits).
    function automatic logic [2:0] last_bit_idx(input logic [1:0] wsel);
        return 3'd4 + {1'b0, wsel};
    endfunction

    // Parity bit owed by the low (5 + wsel) bits of d.
    function automatic logic parity_bit(input logic [7:0] d,
                                        input logic [1:0] wsel,
                                        input par_mode_e  m);
        logic [7:0] mask;
        logic       x;
        logic       r;
        mask = 8'hFF >> (2'd3 - wsel);
        x    = ^(d & mask);
        case (m)
            PAR_ODD:   r = ~x;
            PAR_EVEN:  r = x;
            PAR_MARK:  r = 1'b1;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int DIV_W    = 16,
    parameter int DIV_INIT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] div_byte,
    input  logic       div_lo_wr,
    input  logic       div_hi_wr,
    output logic       os_tick
);
    localparam int HI_W = DIV_W - 8;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] cnt_q;
    logic             tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_W'(DIV_INIT);
        end else begin
            if (div_lo_wr) div_q[7:0]       <= div_byte;
            if (div_hi_wr) div_q[DIV_W-1:8] <= div_byte[HI_W-1:0];
        end
    end

    assign div_eff = (div_q == '0) ? DIV_W'(1) : div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q >= div_eff - DIV_W'(1)) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
            tick_q <= 1'b0;
        end
    end

    assign os_tick = tick_q;

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && div_eff > DIV_W'(1) && !div_lo_wr && !div_hi_wr) |=> !os_tick); // R2

endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_frame_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic [1:0] wlen_sel,
    input  logic       stop_sel,
    input  logic       par_en,
    input  logic [1:0] par_mode,
    input  logic       brk_ctl,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       tx_empty,
    output logic       txd
);
    localparam int CW = $clog2(2 * OSR) + 1;
    localparam logic [CW-1:0] BIT_LAST  = CW'(OSR - 1);
    localparam logic [CW-1:0] STOP_1    = CW'(OSR - 1);
    localparam logic [CW-1:0] STOP_1_5  = CW'(OSR + OSR / 2 - 1);
    localparam logic [CW-1:0] STOP_2    = CW'(2 * OSR - 1);

    tx_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [2:0]      idx_q;
    logic [7:0]      sh_q;
    logic [7:0]      hold_q;
    logic            hold_v_q;
    logic            par_q;
    logic            txd_q;
    logic            txd_d;
    logic [CW-1:0]   stop_lim;
    logic            bit_end;
    logic            stop_end;
    logic            launch;
    logic            accept;

    assign stop_lim = !stop_sel          ? STOP_1 :
                      (wlen_sel == 2'd0) ? STOP_1_5 : STOP_2;
    assign bit_end  = os_tick && (cnt_q == BIT_LAST);
    assign stop_end = os_tick && (cnt_q == stop_lim);
    assign launch   = (state_q == TX_IDLE) && hold_v_q;
    assign accept   = tx_valid && !hold_v_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (launch) state_d = TX_START;
            TX_START:  if (bit_end) state_d = TX_DATA;
            TX_DATA:   if (bit_end && idx_q == last_bit_idx(wlen_sel))
                           state_d = par_en ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) state_d = TX_STOP;
            TX_STOP:   if (stop_end) state_d = TX_IDLE;
            default:   state_d = TX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Bit timing, shifter and holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            idx_q    <= '0;
            sh_q     <= '0;
            hold_q   <= '0;
            hold_v_q <= 1'b0;
            par_q    <= 1'b0;
        end else begin
            if (state_q != state_d || (state_q == TX_DATA && bit_end))
                cnt_q <= '0;
            else if (os_tick && state_q != TX_IDLE)
                cnt_q <= cnt_q + CW'(1);

            if (launch) begin
                idx_q    <= '0;
                sh_q     <= hold_q;
                par_q    <= parity_bit(hold_q, wlen_sel, par_mode_e'(par_mode));
                hold_v_q <= 1'b0;
            end else if (accept) begin
                hold_q   <= tx_data;
                hold_v_q <= 1'b1;
            end

            if (state_q == TX_DATA && bit_end)
                idx_q <= idx_q + 3'd1;
        end
    end

    // Output process
    always_comb begin
        unique case (state_q)
            TX_IDLE:   txd_d = 1'b1;
            TX_START:  txd_d = 1'b0;
            TX_DATA:   txd_d = sh_q[idx_q];
            TX_PARITY: txd_d = par_q;
            TX_STOP:   txd_d = 1'b1;
            default:   txd_d = 1'b1;
        endcase
        if (brk_ctl) txd_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) txd_q <= 1'b1;
        else        txd_q <= txd_d;
    end

    assign txd      = txd_q;
    assign tx_ready = !hold_v_q;
    assign tx_empty = (state_q == TX_IDLE) && !hold_v_q;

    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_v_q && !launch) |=> (hold_v_q && $stable(hold_q))); // R7

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == TX_START && state_q != TX_START && !$past(brk_ctl)) |-> !txd_q); // R3

    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(brk_ctl) |-> !txd_q); // R6

    AST_EMPTY_IMPLIES_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_empty) && !$past(brk_ctl)) |-> txd_q); // R7

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_frame_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [1:0] wlen_sel,
    input  logic       par_en,
    input  logic [1:0] par_mode,
    input  logic       rx_ready,
    input  logic       stat_clr,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       st_overrun,
    output logic       st_parity,
    output logic       st_framing,
    output logic       st_break
);
    localparam int CW = $clog2(OSR) + 1;
    localparam logic [CW-1:0] MID_START = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] BIT_LAST  = CW'(OSR - 1);

    rx_state_e     state_q, state_d;
    logic          rx_m, rx_s;
    logic [CW-1:0] cnt_q;
    logic [2:0]    idx_q;
    logic [7:0]    sh_q;
    logic          zero_q;
    logic          par_rx_q;
    logic          rx_v_q;
    logic [7:0]    rx_d_q;
    logic          ov_q, pe_q, fe_q, brk_q;
    logic          mid_tick;
    logic          bit_mid;
    logic          done;
    logic          ev_fe, ev_brk, ev_pe, ev_ov;

    // Two-stage synchronizer, idles high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rxd;
            rx_s <= rx_m;
        end
    end

    assign mid_tick = os_tick && (cnt_q == MID_START);
    assign bit_mid  = os_tick && (cnt_q == BIT_LAST);
    assign done     = (state_q == RX_STOP) && bit_mid;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:      if (os_tick && !rx_s) state_d = RX_START;
            RX_START:     if (mid_tick) state_d = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:      if (bit_mid && idx_q == last_bit_idx(wlen_sel))
                              state_d = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY:    if (bit_mid) state_d = RX_STOP;
            RX_STOP:      if (bit_mid) state_d = rx_s ? RX_IDLE : RX_WAIT_HIGH;
            RX_WAIT_HIGH: if (rx_s) state_d = RX_IDLE;
            default:      state_d = RX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Sample timing and character assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            idx_q    <= '0;
            sh_q     <= '0;
            zero_q   <= 1'b1;
            par_rx_q <= 1'b0;
        end else begin
            if (state_q != state_d || (state_q == RX_DATA && bit_mid))
                cnt_q <= '0;
            else if (os_tick && state_q != RX_IDLE && state_q != RX_WAIT_HIGH)
                cnt_q <= cnt_q + CW'(1);

            if (state_q == RX_IDLE && state_d == RX_START) begin
                idx_q  <= '0;
                sh_q   <= '0;
                zero_q <= 1'b1;
            end
            if (state_q == RX_DATA && bit_mid) begin
                sh_q[idx_q] <= rx_s;
                idx_q       <= idx_q + 3'd1;
                if (rx_s) zero_q <= 1'b0;
            end
            if (state_q == RX_PARITY && bit_mid) begin
                par_rx_q <= rx_s;
                if (rx_s) zero_q <= 1'b0;
            end
        end
    end

    assign ev_fe  = done && !rx_s;
    assign ev_brk = ev_fe && zero_q;
    assign ev_pe  = done && par_en &&
                    (par_rx_q != parity_bit(sh_q, wlen_sel, par_mode_e'(par_mode)));
    assign ev_ov  = done && rx_v_q && !rx_ready;

    // Output process: character buffer and sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_v_q <= 1'b0;
            rx_d_q <= '0;
            ov_q   <= 1'b0;
            pe_q   <= 1'b0;
            fe_q   <= 1'b0;
            brk_q  <= 1'b0;
        end else begin
            if (done && !(rx_v_q && !rx_ready)) begin
                rx_v_q <= 1'b1;
                rx_d_q <= sh_q;
            end else if (rx_v_q && rx_ready) begin
                rx_v_q <= 1'b0;
            end
            ov_q  <= ev_ov  | (ov_q  & ~stat_clr);
            pe_q  <= ev_pe  | (pe_q  & ~stat_clr);
            fe_q  <= ev_fe  | (fe_q  & ~stat_clr);
            brk_q <= ev_brk | (brk_q & ~stat_clr);
        end
    end

    assign rx_valid   = rx_v_q;
    assign rx_data    = rx_d_q;
    assign st_overrun = ov_q;
    assign st_parity  = pe_q;
    assign st_framing = fe_q;
    assign st_break   = brk_q;

    AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R12

    AST_CONSUME_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && !done) |=> !rx_valid); // R8

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_overrun || st_parity || st_framing) && !stat_clr) |=>
        ($countones({st_overrun, st_parity, st_framing}) >=
         $countones({$past(st_overrun), $past(st_parity), $past(st_framing)}))); // R13

    AST_BREAK_WITH_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
        st_break |-> st_framing); // R11

endmodule

// File: rtl/uart_frame_core.sv
module uart_frame_core #(
    parameter int OSR      = 16,
    parameter int DIV_W    = 16,
    parameter int DIV_INIT = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] div_byte,
    input  logic       div_lo_wr,
    input  logic       div_hi_wr,
    input  logic [1:0] wlen_sel,
    input  logic       stop_sel,
    input  logic       par_en,
    input  logic [1:0] par_mode,
    input  logic       brk_ctl,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       tx_empty,
    output logic       txd,
    input  logic       rxd,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    input  logic       rx_ready,
    input  logic       stat_clr,
    output logic       st_overrun,
    output logic       st_parity,
    output logic       st_framing,
    output logic       st_break
);
    logic os_tick;

    uart_baud_gen #(.DIV_W(DIV_W), .DIV_INIT(DIV_INIT)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_byte  (div_byte),
        .div_lo_wr (div_lo_wr),
        .div_hi_wr (div_hi_wr),
        .os_tick   (os_tick)
    );

    uart_tx_fsm #(.OSR(OSR)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .wlen_sel (wlen_sel),
        .stop_sel (stop_sel),
        .par_en   (par_en),
        .par_mode (par_mode),
        .brk_ctl  (brk_ctl),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .tx_empty (tx_empty),
        .txd      (txd)
    );

    uart_rx_fsm #(.OSR(OSR)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .os_tick    (os_tick),
        .rxd        (rxd),
        .wlen_sel   (wlen_sel),
        .par_en     (par_en),
        .par_mode   (par_mode),
        .rx_ready   (rx_ready),
        .stat_clr   (stat_clr),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .st_overrun (st_overrun),
        .st_parity  (st_parity),
        .st_framing (st_framing),
        .st_break   (st_break)
    );

    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_ready); // R7

endmodule

// File: tb/test_uart_frame_core.sv
`timescale 1ns/1ps
module test_uart_frame_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_byte = '0;
    logic       div_lo_wr = 1'b0, div_hi_wr = 1'b0;
    logic [1:0] wlen_sel = 2'd3;
    logic       stop_sel = 1'b0, par_en = 1'b0;
    logic [1:0] par_mode = 2'd0;
    logic       brk_ctl = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready, tx_empty, txd;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_ready = 1'b0, stat_clr = 1'b0;
    logic       st_overrun, st_parity, st_framing, st_break;
    logic       lb = 1'b0;
    logic       rxd_drv = 1'b1;
    logic       rxd_w;

    int n_run = 0, n_fail = 0;
    int bit_clk = 16;
    int cyc = 0;
    bit finished = 0;

    assign rxd_w = lb ? txd : rxd_drv;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_frame_core i_uart_frame_core (
        .clk(clk), .rst_n(rst_n), .div_byte(div_byte), .div_lo_wr(div_lo_wr),
        .div_hi_wr(div_hi_wr), .wlen_sel(wlen_sel), .stop_sel(stop_sel),
        .par_en(par_en), .par_mode(par_mode), .brk_ctl(brk_ctl),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .tx_empty(tx_empty), .txd(txd), .rxd(rxd_w), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .stat_clr(stat_clr),
        .st_overrun(st_overrun), .st_parity(st_parity),
        .st_framing(st_framing), .st_break(st_break)
    );

    // {wlen[15:14], stop[13], par_en[12], mode[11:10], 2'b0, data[7:0]}
    localparam int NV = 9;
    localparam logic [15:0] VEC [NV] = '{
        {2'd3, 1'b0, 1'b0, 2'd0, 2'b0, 8'hA5},
        {2'd3, 1'b0, 1'b1, 2'd0, 2'b0, 8'h3C},
        {2'd3, 1'b1, 1'b1, 2'd1, 2'b0, 8'h7F},
        {2'd0, 1'b0, 1'b1, 2'd2, 2'b0, 8'h1F},
        {2'd1, 1'b0, 1'b1, 2'd3, 2'b0, 8'h2A},
        {2'd2, 1'b1, 1'b0, 2'd0, 2'b0, 8'h55},
        {2'd0, 1'b1, 1'b1, 2'd1, 2'b0, 8'h13},
        {2'd3, 1'b1, 1'b1, 2'd0, 2'b0, 8'h00},
        {2'd0, 1'b0, 1'b0, 2'd0, 2'b0, 8'hE7}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_par(input int d, input int nb, input int mode);
        int ones = 0;
        for (int i = 0; i < nb; i++) ones += (d >> i) & 1;
        case (mode)
            0:       return (ones % 2 == 0) ? 1 : 0;
            1:       return ones % 2;
            2:       return 1;
            default: return 0;
        endcase
    endfunction

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_div(input int d);
        @(negedge clk); div_byte = d[7:0];  div_lo_wr = 1'b1;
        @(negedge clk); div_lo_wr = 1'b0; div_byte = d[15:8]; div_hi_wr = 1'b1;
        @(negedge clk); div_hi_wr = 1'b0;
        bit_clk = 16 * d;
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk); tx_valid = 1'b1; tx_data = d;
        while (!tx_ready) @(negedge clk);
        @(negedge clk); tx_valid = 1'b0;
    endtask

    task automatic wait_level(input logic v);
        int w = 0;
        while (txd !== v && w < 5000) begin @(negedge clk); w++; end
    endtask

    task automatic wait_tx_idle();
        int w = 0;
        while (!tx_empty && w < 5000) begin @(negedge clk); w++; end
    endtask

    task automatic wait_rx();
        int w = 0;
        while (!rx_valid && w < 4 * bit_clk) begin @(negedge clk); w++; end
    endtask

    task automatic consume();
        @(negedge clk); rx_ready = 1'b1;
        @(negedge clk); rx_ready = 1'b0;
    endtask

    task automatic clear_stat();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
    endtask

    // Decode one frame from txd at mid-bit points
    task automatic tx_decode(input int nb, input bit pe, input int expd, input int expp);
        int got = 0;
        wait_level(1'b0);
        clocks(bit_clk / 2);
        chk(txd == 1'b0, "R3", "start bit level", int'(txd), 0);
        for (int i = 0; i < nb; i++) begin
            clocks(bit_clk);
            got |= int'(txd) << i;
        end
        if (pe) begin
            clocks(bit_clk);
            chk(int'(txd) == expp, "R4", "parity bit", int'(txd), expp);
        end
        clocks(bit_clk);
        chk(txd == 1'b1, "R3", "stop bit level", int'(txd), 1);
        chk(got == expd, "R3", "data bits lsb first", got, expd);
    endtask

    // Falling-edge spacing of two back-to-back 0xFF frames
    task automatic measure(input int exp_len, input string req);
        int t1 = 0, t2 = 0;
        fork
            begin send(8'hFF); send(8'hFF); end
            begin
                wait_level(1'b0); t1 = cyc;
                wait_level(1'b1);
                wait_level(1'b0); t2 = cyc;
                chk(tx_ready && !tx_empty, "R7", "ready while second frame on line",
                    int'({tx_ready, tx_empty}), 2);
            end
        join
        chk((t2 - t1) >= exp_len - 2 && (t2 - t1) <= exp_len + 4, req,
            "frame length in cycles", t2 - t1, exp_len);
        wait_tx_idle();
        clocks(2);
        chk(tx_empty && txd, "R7", "empty and idle high after frames",
            int'({tx_empty, txd}), 3);
    endtask

    task automatic drive_frame(input int nb, input logic [7:0] d, input bit has_par,
                               input bit pv, input bit stop_v);
        @(negedge clk); rxd_drv = 1'b0; clocks(bit_clk);
        for (int i = 0; i < nb; i++) begin rxd_drv = d[i]; clocks(bit_clk); end
        if (has_par) begin rxd_drv = pv; clocks(bit_clk); end
        rxd_drv = stop_v; clocks(bit_clk);
        rxd_drv = 1'b1; clocks(bit_clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        clocks(4);
        rst_n = 1'b1;
        clocks(2);
        // R1 reset state
        chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
        chk(tx_ready && tx_empty, "R1", "tx_ready/tx_empty after reset",
            int'({tx_ready, tx_empty}), 3);
        chk(!rx_valid, "R1", "rx_valid after reset", int'(rx_valid), 0);
        chk({st_overrun, st_parity, st_framing, st_break} == 4'b0, "R1",
            "status after reset", int'({st_overrun, st_parity, st_framing, st_break}), 0);

        // R2 reset divisor 1: 8 data, no parity, 2 stops = 11 bits of 16
        wlen_sel = 2'd3; stop_sel = 1'b1; par_en = 1'b0;
        measure(11 * 16, "R2");

        set_div(2);
        // R5 1.5 stop bits on 5-bit words: 7.5 bits of 32
        wlen_sel = 2'd0; stop_sel = 1'b1;
        measure(240, "R5");
        // R5 one stop bit on 5-bit words: 7 bits
        stop_sel = 1'b0;
        measure(224, "R5");

        // Vector sweep in loopback: R3 R4 R8
        lb = 1'b1;
        for (int v = 0; v < NV; v++) begin
            int nb, m, p;
            wlen_sel = VEC[v][15:14]; stop_sel = VEC[v][13];
            par_en = VEC[v][12]; par_mode = VEC[v][11:10];
            nb = 5 + int'(VEC[v][15:14]);
            m  = int'(VEC[v][7:0]) & ((1 << nb) - 1);
            p  = exp_par(m, nb, int'(VEC[v][11:10]));
            clocks(2);
            send(VEC[v][7:0]);
            tx_decode(nb, VEC[v][12], m, p);
            wait_rx();
            chk(rx_valid && int'(rx_data) == m, "R8", "loopback character",
                int'(rx_data), m);
            chk({st_overrun, st_parity, st_framing, st_break} == 4'b0, "R4",
                "no error on clean frame",
                int'({st_overrun, st_parity, st_framing, st_break}), 0);
            consume();
            chk(!rx_valid, "R8", "rx_valid drops on rx_ready", int'(rx_valid), 0);
            wait_tx_idle();
            clocks(bit_clk);
        end
        lb = 1'b0;
        clocks(bit_clk);

        // R6 break transmit
        @(negedge clk); brk_ctl = 1'b1;
        clocks(2);
        chk(txd == 1'b0, "R6", "txd low under break", int'(txd), 0);
        clocks(bit_clk * 3);
        chk(txd == 1'b0, "R6", "txd held low under break", int'(txd), 0);
        @(negedge clk); brk_ctl = 1'b0;
        clocks(2);
        chk(txd == 1'b1, "R6", "txd high after break release", int'(txd), 1);

        // R9 parity error, character still delivered; R13 sticky then cleared
        wlen_sel = 2'd3; stop_sel = 1'b0; par_en = 1'b1; par_mode = 2'd1;
        drive_frame(8, 8'h01, 1'b1, 1'b0, 1'b1);
        wait_rx();
        chk(st_parity && !st_framing, "R9", "parity error flag",
            int'({st_parity, st_framing}), 2);
        chk(int'(rx_data) == 8'h01, "R9", "char delivered despite parity", int'(rx_data), 1);
        consume();
        clocks(bit_clk * 2);
        chk(st_parity, "R13", "parity flag still set", int'(st_parity), 1);
        clear_stat();
        chk(!st_parity, "R13", "parity flag cleared", int'(st_parity), 0);

        // R4 parity disabled: wrong-looking bit is data, no check
        par_en = 1'b0;
        drive_frame(8, 8'h01, 1'b0, 1'b0, 1'b1);
        wait_rx();
        chk(!st_parity && int'(rx_data) == 1, "R4", "no parity check when disabled",
            int'(st_parity), 0);
        consume();

        // R10 framing error
        drive_frame(8, 8'h81, 1'b0, 1'b0, 1'b0);
        wait_rx();
        chk(st_framing && !st_break, "R10", "framing without break",
            int'({st_framing, st_break}), 2);
        consume();
        clear_stat();

        // R11 break detect, then recovery
        @(negedge clk); rxd_drv = 1'b0;
        clocks(bit_clk * 12);
        chk(st_break && st_framing, "R11", "break and framing flags",
            int'({st_break, st_framing}), 3);
        chk(rx_valid && rx_data == 8'h00, "R11", "zero char on break", int'(rx_data), 0);
        consume();
        clocks(bit_clk * 2);
        chk(!rx_valid, "R11", "no new char while line held low", int'(rx_valid), 0);
        rxd_drv = 1'b1;
        clocks(bit_clk);
        clear_stat();
        drive_frame(8, 8'h5A, 1'b0, 1'b0, 1'b1);
        wait_rx();
        chk(int'(rx_data) == 8'h5A && !st_framing, "R11", "receive after break",
            int'(rx_data), 8'h5A);
        consume();

        // R12 overrun keeps the older character
        drive_frame(8, 8'h11, 1'b0, 1'b0, 1'b1);
        drive_frame(8, 8'h22, 1'b0, 1'b0, 1'b1);
        chk(st_overrun, "R12", "overrun flag", int'(st_overrun), 1);
        chk(int'(rx_data) == 8'h11, "R12", "older char kept", int'(rx_data), 8'h11);
        consume();
        chk(!rx_valid, "R8", "rx_valid drops after consume", int'(rx_valid), 0);
        clear_stat();
        chk({st_overrun, st_parity, st_framing, st_break} == 4'b0, "R13",
            "all flags cleared", int'({st_overrun, st_parity, st_framing, st_break}), 0);

        // R14 short low glitch is ignored
        @(negedge clk); rxd_drv = 1'b0;
        clocks(4);
        rxd_drv = 1'b1;
        clocks(bit_clk * 12);
        chk(!rx_valid && !st_framing, "R14", "glitch starts no character",
            int'({rx_valid, st_framing}), 0);

        finished = 1;
        summary();
    end

endmodule